// File: doc/BRIEF.md
# Overcurrent Fault Counter and Hiccup Sequencer

This block sits in the digital core of a synchronous buck controller. It watches two overcurrent comparator flags, one for the high-side switch and one for the low-side switch, and samples them once per switching cycle on a strobe. An up/down counter integrates the samples. A cycle with an overcurrent adds one. A clean cycle takes one away. When the count reaches the trip level, the block declares a fault and starts a hiccup retry sequence.

In hiccup the block asks the soft-start timer for a number of dummy soft-starts, with both gate drives held off, and then for one real soft-start. The number of dummy soft-starts depends on when the fault appeared. A fault that appears while the converter is still in its initial start-up gets more dummies than a fault that appears in steady conversion. The sequence repeats for as long as faults keep coming back. A short-circuit flag for the power-good logic stays raised from the fault until a real soft-start finishes cleanly. The high-side comparator also cuts the present high-side on-pulse, which limits current pulse by pulse. When calibration reports that no current-set resistor is fitted, all overcurrent sensing is ignored.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: On a clock edge where `cyc_stb` is 1 and either `hs_oc` or `ls_oc` is 1 (with `sense_off` 0), the internal fault count rises by one. With the default trip level, three such strobes in a row from a count of zero declare a fault, whichever comparator fires.
- R2: On a `cyc_stb` edge with neither flag active, the count falls by one but never below zero. Any number of clean strobes from zero, followed by two overcurrent strobes, gives no fault.
- R3: The strobe that brings the count to the trip level (default 3) makes `fault` go to 1 for exactly one cycle, in the cycle after that edge. The count returns to zero.
- R4: A fault declared while `in_startup` is 0 issues four `ss_req` pulses with `ss_dummy` 1. The first comes with the fault and the rest each follow a `ss_done` pulse. The fourth `ss_done` after the fault then gives one `ss_req` with `ss_dummy` 0, which is the real attempt.
- R5: A fault declared while `in_startup` is 1 issues five dummy requests before the real request, following the same pattern as R4.
- R6: A fault during the real attempt starts a new hiccup sequence. A `ss_done` during the real attempt with no fault ends the hiccup. After that, `ss_done` has no effect.
- R7: While `hs_oc` is 1 (with `sense_off` 0), `hs_drv_en` is 0 in the same cycle. It stays 0 until the clock edge that samples `cyc_stb` as 1.
- R8: While `sense_off` is 1, `hs_oc` and `ls_oc` have no effect: they neither count toward a fault nor cut `hs_drv_en`.
- R9: While `ss_dummy` is 1, `hs_drv_en` and `ls_drv_en` are both 0, and `cyc_stb` does not count.
- R10: `short_flag` rises together with `fault` and falls in the cycle after the `ss_done` that completes a real attempt.
- R11: While `rst_n` is 0, `fault`, `ss_req`, `ss_dummy` and `short_flag` are 0. The count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_stb | input | 1 | One-cycle strobe per switching cycle |
| hs_oc | input | 1 | High-side overcurrent comparator output |
| ls_oc | input | 1 | Low-side overcurrent comparator output |
| sense_off | input | 1 | Calibration found no current-set resistor; ignore the comparators |
| hs_on_req | input | 1 | High-side on request from the PWM |
| ls_on_req | input | 1 | Low-side on request from the PWM |
| ss_done | input | 1 | One-cycle pulse when a soft-start timeout ends |
| in_startup | input | 1 | Converter is still in its initial start-up |
| fault | output | 1 | One-cycle pulse when a fault is declared |
| ss_req | output | 1 | One-cycle pulse requesting a soft-start |
| ss_dummy | output | 1 | Requested or running soft-start is a dummy |
| short_flag | output | 1 | Short-circuit indication for power-good |
| hs_drv_en | output | 1 | High-side gate-drive enable |
| ls_drv_en | output | 1 | Low-side gate-drive enable |

## Verification
The fault count cannot be seen at the ports. A wrong count shows up as a `fault` pulse that comes one strobe early or late, or never comes, after a known pattern of overcurrent and clean strobes. A wrong dummy counter or sequencer state shows up within one `ss_done` as a request of the wrong kind, or as gate drives enabled during a dummy. A stuck pulse-kill latch shows up in `hs_drv_en` in the very next cycle. The bench compares every output against a behavioural model on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

   typedef enum logic [1:0] {
      HIC_RUN   = 2'd0,
      HIC_DUMMY = 2'd1,
      HIC_REAL  = 2'd2
   } hic_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ocp_fault_counter.sv
module ocp_fault_counter #(
   parameter int TRIP_LEVEL = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic oc_any,
   input  logic freeze,
   output logic trip
);
   localparam int CW = $clog2(TRIP_LEVEL + 1);
   localparam logic [CW-1:0] LAST_STEP = CW'(TRIP_LEVEL - 1);

   logic [CW-1:0] cnt_q;
   logic          at_edge;
   logic          count_en;

   if (TRIP_LEVEL < 2) begin : g_bad_trip
      $error("ocp_fault_counter: TRIP_LEVEL must be at least 2");
   end

   assign count_en = cyc_stb & ~freeze;
   assign at_edge  = (cnt_q == LAST_STEP);
   assign trip     = count_en & oc_any & at_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (freeze || trip) begin
         cnt_q <= '0;
      end else if (count_en) begin
         if (oc_any) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq
   import ocp_hiccup_pkg::*;
#(
   parameter int DUMMY_RUN   = 4,
   parameter int DUMMY_START = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip,
   input  logic       ss_done,
   input  logic       in_startup,
   output logic       fault,
   output logic       ss_req,
   output logic       short_flag,
   output hic_state_e state
);
   localparam int DMAX = max_of(DUMMY_RUN, DUMMY_START);
   localparam int DW   = $clog2(DMAX + 1);
   localparam logic [DW-1:0] LOAD_RUN   = DW'(DUMMY_RUN);
   localparam logic [DW-1:0] LOAD_START = DW'(DUMMY_START);

   hic_state_e    st_q, st_d;
   logic [DW-1:0] left_q, left_d;
   logic          fault_d, req_d, short_d;
   logic          fault_q, req_q, short_q;

   if (DUMMY_RUN < 1 || DUMMY_START < 1) begin : g_bad_dummy
      $error("ocp_hiccup_seq: dummy counts must be at least 1");
   end

   always_comb begin
      st_d    = st_q;
      left_d  = left_q;
      fault_d = 1'b0;
      req_d   = 1'b0;
      short_d = short_q;
      if (trip) begin
         fault_d = 1'b1;
         req_d   = 1'b1;
         short_d = 1'b1;
         st_d    = HIC_DUMMY;
         left_d  = in_startup ? LOAD_START : LOAD_RUN;
      end else begin
         unique case (st_q)
            HIC_DUMMY: begin
               if (ss_done) begin
                  req_d = 1'b1;
                  if (left_q == DW'(1)) begin
                     st_d = HIC_REAL;
                  end
                  left_d = left_q - 1'b1;
               end
            end
            HIC_REAL: begin
               if (ss_done) begin
                  st_d    = HIC_RUN;
                  short_d = 1'b0;
               end
            end
            default: begin
               st_d = HIC_RUN;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= HIC_RUN;
         left_q  <= '0;
         fault_q <= 1'b0;
         req_q   <= 1'b0;
         short_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         left_q  <= left_d;
         fault_q <= fault_d;
         req_q   <= req_d;
         short_q <= short_d;
      end
   end

   assign fault      = fault_q;
   assign ss_req     = req_q;
   assign short_flag = short_q;
   assign state      = st_q;

endmodule

// File: rtl/ocp_pulse_limiter.sv
module ocp_pulse_limiter #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic hs_oc_m,
   input  logic hs_on_req,
   output logic hs_cut
);
   if (ENABLE) begin : g_limit
      logic kill_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            kill_q <= 1'b0;
         end else if (cyc_stb) begin
            kill_q <= 1'b0;
         end else if (hs_oc_m && hs_on_req) begin
            kill_q <= 1'b1;
         end
      end
      assign hs_cut = kill_q | hs_oc_m;
   end else begin : g_no_limit
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ cyc_stb ^ hs_oc_m ^ hs_on_req;
      assign hs_cut    = 1'b0;
   end

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
   import ocp_hiccup_pkg::*;
#(
   parameter int TRIP_LEVEL  = 3,
   parameter int DUMMY_RUN   = 4,
   parameter int DUMMY_START = 5,
   parameter bit PULSE_LIMIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic hs_oc,
   input  logic ls_oc,
   input  logic sense_off,
   input  logic hs_on_req,
   input  logic ls_on_req,
   input  logic ss_done,
   input  logic in_startup,
   output logic fault,
   output logic ss_req,
   output logic ss_dummy,
   output logic short_flag,
   output logic hs_drv_en,
   output logic ls_drv_en
);
   localparam int NSENSE = 2;

   logic [NSENSE-1:0] oc_raw;
   logic [NSENSE-1:0] oc_m;
   logic              oc_any;
   logic              trip;
   logic              in_dummy;
   logic              hs_cut;
   hic_state_e        state;

   assign oc_raw = {ls_oc, hs_oc};

   for (genvar i = 0; i < NSENSE; i++) begin : g_mask
      assign oc_m[i] = oc_raw[i] & ~sense_off;
   end

   assign oc_any   = |oc_m;
   assign in_dummy = (state == HIC_DUMMY);

   ocp_fault_counter #(
      .TRIP_LEVEL (TRIP_LEVEL)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_stb (cyc_stb),
      .oc_any  (oc_any),
      .freeze  (in_dummy),
      .trip    (trip)
   );

   ocp_hiccup_seq #(
      .DUMMY_RUN   (DUMMY_RUN),
      .DUMMY_START (DUMMY_START)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .trip       (trip),
      .ss_done    (ss_done),
      .in_startup (in_startup),
      .fault      (fault),
      .ss_req     (ss_req),
      .short_flag (short_flag),
      .state      (state)
   );

   ocp_pulse_limiter #(
      .ENABLE (PULSE_LIMIT)
   ) u_lim (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_stb   (cyc_stb),
      .hs_oc_m   (oc_m[0]),
      .hs_on_req (hs_on_req),
      .hs_cut    (hs_cut)
   );

   assign ss_dummy  = in_dummy;
   assign hs_drv_en = hs_on_req & ~hs_cut & ~in_dummy;
   assign ls_drv_en = ls_on_req & ~in_dummy;

endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic hs_oc,
   input logic sense_off,
   input logic ss_done,
   input logic fault,
   input logic ss_req,
   input logic ss_dummy,
   input logic short_flag,
   input logic hs_drv_en,
   input logic ls_drv_en
);
   p_fault_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   p_fault_starts_dummy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (ss_req && ss_dummy && short_flag));

   p_real_after_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_req && !ss_dummy) |-> $past(ss_dummy));

   p_hs_cut_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_oc && !sense_off) |-> !hs_drv_en);

   p_sense_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sense_off |=> !fault);

   p_dummy_gates_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_dummy |-> (!hs_drv_en && !ls_drv_en));

   p_short_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(short_flag) |-> ($past(ss_done) && !ss_dummy));

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hs_oc      (hs_oc),
   .sense_off  (sense_off),
   .ss_done    (ss_done),
   .fault      (fault),
   .ss_req     (ss_req),
   .ss_dummy   (ss_dummy),
   .short_flag (short_flag),
   .hs_drv_en  (hs_drv_en),
   .ls_drv_en  (ls_drv_en)
);

// File: tb/ocp_hiccup_ctrl_bench.sv
`timescale 1ns/100ps
module ocp_hiccup_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_stb = 0, hs_oc = 0, ls_oc = 0, sense_off = 0;
   logic hs_on_req = 0, ls_on_req = 0, ss_done = 0, in_startup = 0;
   logic fault, ss_req, ss_dummy, short_flag, hs_drv_en, ls_drv_en;

   int checks = 0;
   int failures = 0;
   bit done_flag = 0;
   int n_dummy_req = 0;
   int n_real_req = 0;
   int n_fault = 0;

   // behavioural reference: 0 run, 1 dummy, 2 real
   int m_st = 0, m_cnt = 0, m_left = 0;
   bit m_fault = 0, m_req = 0, m_short = 0, m_kill = 0;

   always #2.5 clk = ~clk;

   ocp_hiccup_ctrl u_ocp_hiccup_ctrl (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .hs_oc(hs_oc), .ls_oc(ls_oc),
      .sense_off(sense_off), .hs_on_req(hs_on_req), .ls_on_req(ls_on_req),
      .ss_done(ss_done), .in_startup(in_startup), .fault(fault), .ss_req(ss_req),
      .ss_dummy(ss_dummy), .short_flag(short_flag), .hs_drv_en(hs_drv_en),
      .ls_drv_en(ls_drv_en));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit oc, hoc, trip;
      hoc = hs_oc && !sense_off;
      oc = (hs_oc || ls_oc) && !sense_off;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_left = 0; m_fault = 0; m_req = 0; m_short = 0; m_kill = 0;
         return;
      end
      if (cyc_stb) m_kill = 0;
      else if (hoc && hs_on_req) m_kill = 1;
      trip = (m_st != 1) && cyc_stb && oc && (m_cnt == 2);
      m_fault = 0; m_req = 0;
      if (trip) begin
         m_fault = 1; m_req = 1; m_short = 1; m_st = 1; m_cnt = 0;
         m_left = in_startup ? 5 : 4;
      end else if (m_st == 1) begin
         m_cnt = 0;
         if (ss_done) begin
            m_req = 1;
            m_left = m_left - 1;
            if (m_left == 0) m_st = 2;
         end
      end else begin
         if (cyc_stb) begin
            if (oc) m_cnt = m_cnt + 1;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
         end
         if (ss_done && m_st == 2) begin
            m_st = 0; m_short = 0;
         end
      end
   endtask

   always @(posedge clk) begin
      bit e_hs, e_ls;
      model_step();
      #1;
      e_hs = (m_st != 1) && hs_on_req && !m_kill && !(hs_oc && !sense_off);
      e_ls = (m_st != 1) && ls_on_req;
      chk(fault == m_fault, "R3 fault", fault, m_fault);
      chk(ss_req == m_req, "R4 ss_req", ss_req, m_req);
      chk(ss_dummy == (m_st == 1), "R5 ss_dummy", ss_dummy, m_st == 1);
      chk(short_flag == m_short, "R10 short_flag", short_flag, m_short);
      chk(hs_drv_en == e_hs, "R7 hs_drv_en", hs_drv_en, e_hs);
      chk(ls_drv_en == e_ls, "R9 ls_drv_en", ls_drv_en, e_ls);
      if (ss_req && ss_dummy) n_dummy_req++;
      if (ss_req && !ss_dummy) n_real_req++;
      if (fault) n_fault++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input bit h, input bit l);
      @(negedge clk);
      cyc_stb = 1; hs_oc = h; ls_oc = l;
      @(negedge clk);
      cyc_stb = 0; hs_oc = 0; ls_oc = 0;
      tick(2);
   endtask

   task automatic done_pulse();
      @(negedge clk); ss_done = 1;
      @(negedge clk); ss_done = 0;
      tick(2);
   endtask

   task automatic clear_counts();
      n_dummy_req = 0; n_real_req = 0; n_fault = 0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(5 * 20000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(3);
      // R11 reset state
      chk(!fault && !ss_req && !ss_dummy && !short_flag, "R11 reset outputs",
          {fault, ss_req, ss_dummy, short_flag}, 0);
      rst_n = 1;
      hs_on_req = 1; ls_on_req = 1;
      tick(2);

      // R2: clean strobes at zero, then two overcurrent strobes: no fault
      clear_counts();
      repeat (5) strobe(0, 0);
      strobe(1, 0); strobe(0, 1);
      chk(n_fault == 0, "R2 saturate at zero", n_fault, 0);
      strobe(0, 0); strobe(0, 0); strobe(1, 0); strobe(1, 1);
      chk(n_fault == 0, "R2 decrement", n_fault, 0);

      // R1 / R3 / R4: third net overcurrent trips, normal conversion
      strobe(0, 1);
      chk(n_fault == 1, "R1 trip on third count", n_fault, 1);
      chk(ss_dummy == 1, "R9 dummy after fault", ss_dummy, 1);
      chk(short_flag == 1, "R10 short set", short_flag, 1);
      strobe(1, 1); strobe(1, 1); strobe(1, 1);
      chk(n_fault == 1, "R9 strobes ignored in dummy", n_fault, 1);
      repeat (4) done_pulse();
      chk(n_dummy_req == 4, "R4 dummy count", n_dummy_req, 4);
      chk(n_real_req == 1 && !ss_dummy, "R4 real request", n_real_req, 1);
      chk(short_flag == 1, "R10 short held in real", short_flag, 1);
      done_pulse();
      chk(short_flag == 0, "R6 real done clears short", short_flag, 0);
      done_pulse();
      chk(n_real_req == 1 && !ss_dummy, "R6 done ignored in run", n_real_req, 1);

      // R5 / R6: start-up fault, then fault again in real attempt
      in_startup = 1;
      clear_counts();
      strobe(1, 0); strobe(1, 0); strobe(1, 0);
      chk(n_fault == 1, "R5 start-up trip", n_fault, 1);
      repeat (4) done_pulse();
      chk(ss_dummy == 1, "R5 still dummy after four", ss_dummy, 1);
      done_pulse();
      chk(n_dummy_req == 5 && n_real_req == 1, "R5 five dummies", n_dummy_req, 5);
      clear_counts();
      strobe(0, 1); strobe(0, 1); strobe(0, 1);
      chk(n_fault == 1 && ss_dummy, "R6 retry fault", n_fault, 1);
      in_startup = 0;
      repeat (5) done_pulse();
      chk(n_dummy_req == 5 && n_real_req == 1, "R6 second hiccup", n_dummy_req, 5);
      done_pulse();
      chk(!short_flag && !ss_dummy, "R6 leave hiccup", short_flag, 0);

      // R7 pulse by pulse limiting
      @(negedge clk); hs_oc = 1;
      #1 chk(hs_drv_en == 0, "R7 immediate cut", hs_drv_en, 0);
      @(negedge clk); hs_oc = 0;
      tick(3);
      chk(hs_drv_en == 0, "R7 held until strobe", hs_drv_en, 0);
      strobe(0, 0);
      chk(hs_drv_en == 1, "R7 released by strobe", hs_drv_en, 1);

      // R8 sensing disabled
      sense_off = 1;
      clear_counts();
      repeat (6) strobe(1, 1);
      chk(n_fault == 0, "R8 no fault", n_fault, 0);
      @(negedge clk); hs_oc = 1;
      #1 chk(hs_drv_en == 1, "R8 no cut", hs_drv_en, 1);
      @(negedge clk); hs_oc = 0;
      sense_off = 0;
      strobe(0, 0);
      strobe(1, 0); strobe(1, 0);
      chk(n_fault == 0, "R8 count unchanged", n_fault, 0);
      strobe(1, 0);
      chk(n_fault == 1, "R1 trip after re-enable", n_fault, 1);
      tick(4);
      finish_run();
   end
endmodule